// File: doc/BRIEF.md
# UART Receive Buffer with FIFO and Status Registers

This block sits between a serial receiver and the register bus of a memory-mapped UART. The receiver delivers bytes one per cycle on a push port, and it can also signal a line break. Software reads the received data, the buffer occupancy and the line error flags through a small register port. The block drives a data-ready line and two interrupt source lines, one for receive and one for error, to the interrupt logic.

Bit 0 of the control register selects one of two modes. In FIFO mode, bytes queue in a circular buffer of `DEPTH` entries. In holding mode, each byte overwrites a single register. The FIFO contents are kept across mode changes. Register reads take effect in the same cycle: the read data is valid while `reg_rd` is high, and any side effect (a pop or a clear) happens at the next clock edge.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the block is in holding mode. The FIFO is empty, `data_ready`, `irq_rx`, `irq_err` and `tx_flush` are low, and the control, status and error registers read as zero.
- R2: The control register is at address 0.
  - Bit 0 selects FIFO mode and reads back.
  - Writing 1 to bit 1 empties the receive FIFO. In FIFO mode it also clears `data_ready` and discards a byte arriving in the same cycle.
  - Writing 1 to bit 2 raises `tx_flush` for exactly one cycle, starting the cycle after the write.
  - Bits 1 and 2 always read back as 0.
- R3: The status register is at address 1.
  - Bits [7:0] hold the FIFO occupancy, and bit 8 holds the full flag.
  - When the FIFO is full, bits [7:0] read as 0.
  - All other bits read as 0.
- R4: In FIFO mode, a read of the receive buffer at address 3 returns the oldest stored byte in bits [7:0] and removes it. Bytes leave in the order they arrived.
- R5: Every accepted incoming byte or break sets `data_ready`, in either mode and even when the FIFO drops the byte. In FIFO mode, a read that removes the last byte clears `data_ready`, and a read that leaves bytes behind keeps it set.
- R6: A byte arriving while the FIFO is full is dropped and sets `irq_err`. The stored bytes are not changed.
- R7: In FIFO mode, reading address 3 while the FIFO is empty returns 0 and sets `irq_err`.
- R8: In holding mode, each incoming byte replaces the holding register. A read of address 3 returns the last byte and clears `data_ready`. The FIFO is not touched in this mode.
- R9: A break is handled as an incoming 0x00 byte in the current mode, and it sets bit 3 of the error register. If `push_valid` is high in the same cycle, the break takes precedence and `push_data` is discarded.
- R10: The error register is at address 2. Its bits are overrun (bit 0), parity (bit 1), frame (bit 2) and break (bit 3). A read returns the value and clears the register. A break in the same cycle as the read still leaves bit 3 set.
- R11: Every accepted byte sets `irq_rx`. `src_clr[0]` clears `irq_rx` and `src_clr[1]` clears `irq_err`. If a set and a clear occur in the same cycle, the set wins.
- R12: A push and a pop in the same cycle, on a FIFO that is neither empty nor full, leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Byte from the receiver is valid |
| push_data | input | 8 | Received byte |
| brk_evt | input | 1 | Line break detected |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 error, 3 receive buffer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle the read is issued |
| src_clr | input | 2 | Source clear: bit 0 clears receive, bit 1 clears error |
| data_ready | output | 1 | Received data available |
| irq_rx | output | 1 | Receive interrupt source |
| irq_err | output | 1 | Error interrupt source |
| tx_flush | output | 1 | One-cycle transmit FIFO reset request |

## Verification
The FIFO is driven with several patterns:
- Short bursts that are drained in full show the ordering and the point at which `data_ready` falls.
- A fill to capacity plus one extra byte shows both the count-reads-zero rule and that the overflow byte is really dropped, because the drain that follows must return exactly `DEPTH` bytes.
- A simultaneous push and pop separates correct occupancy accounting from a counter that favours one side.
- A switch to holding mode and back shows that the two storage paths are independent.

Breaks are applied alone, together with a push, and together with an error-register read. These cases tell apart the byte precedence rule and the ordering between the clear and the set.

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  input  logic [7:0]  push_data,
  input  logic        brk_evt,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [1:0]  src_clr,
  output logic        data_ready,
  output logic        irq_rx,
  output logic        irq_err,
  output logic        tx_flush
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [7:0]    hold;
  logic [3:0]    err_q;
  logic          fifo_en;

  logic       in_valid, full, empty, rd_buf, rd_err, wr_ctl, rx_flush;
  logic       accepted, do_push, do_pop;
  logic [7:0] in_byte, cnt8;
  logic       unused_wdata;

  assign in_valid = push_valid | brk_evt;
  assign in_byte  = brk_evt ? 8'h00 : push_data;
  assign full     = (cnt == FULLC);
  assign empty    = (cnt == '0);
  assign rd_buf   = reg_rd && reg_addr == 2'd3;
  assign rd_err   = reg_rd && reg_addr == 2'd2;
  assign wr_ctl   = reg_wr && reg_addr == 2'd0;
  assign rx_flush = wr_ctl && reg_wdata[1];
  assign accepted = in_valid && !(rx_flush && fifo_en);
  assign do_push  = accepted && fifo_en && !full;
  assign do_pop   = rd_buf && fifo_en && !empty && !rx_flush;
  assign cnt8     = 8'(cnt);
  assign unused_wdata = ^reg_wdata[31:3];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else if (rx_flush) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en    <= 1'b0;
      hold       <= '0;
      err_q      <= '0;
      data_ready <= 1'b0;
      irq_rx     <= 1'b0;
      irq_err    <= 1'b0;
      tx_flush   <= 1'b0;
    end else begin
      tx_flush <= wr_ctl && reg_wdata[2];
      if (wr_ctl) fifo_en <= reg_wdata[0];
      if (accepted && !fifo_en) hold <= in_byte;

      if (rd_err)  err_q <= '0;
      if (brk_evt) err_q[3] <= 1'b1;

      if (rx_flush && fifo_en)           data_ready <= 1'b0;
      else if (do_pop && cnt == CW'(1))  data_ready <= 1'b0;
      else if (rd_buf && !fifo_en)       data_ready <= 1'b0;
      if (accepted)                      data_ready <= 1'b1;

      if (src_clr[0]) irq_rx <= 1'b0;
      if (accepted)   irq_rx <= 1'b1;
      if (src_clr[1]) irq_err <= 1'b0;
      if ((accepted && fifo_en && full) || (rd_buf && fifo_en && empty && !rx_flush))
        irq_err <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {31'd0, fifo_en};
      2'd1:    reg_rdata = {23'd0, full, full ? 8'd0 : cnt8};
      2'd2:    reg_rdata = {28'd0, err_q};
      default: reg_rdata = !fifo_en ? {24'd0, hold} : (empty ? 32'd0 : {24'd0, mem[rp]});
    endcase
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULLC);

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && fifo_en && in_valid && !reg_rd && !reg_wr) |=> (full && irq_err));

  p_empty_read_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && fifo_en && empty && !reg_wr) |=> irq_err);

  p_push_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !reg_wr) |=> (data_ready && irq_rx));

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !brk_evt) |=> (err_q == 4'd0));

  p_break_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> err_q[3]);

  p_push_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && push_valid && rd_buf && !empty && !full && !reg_wr) |=> $stable(cnt));

endmodule

// File: tb/uart_rx_buffer_tb.sv
`timescale 1ns/1ps
module uart_rx_buffer_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0, brk_evt = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  push_data = '0;
  logic [1:0]  reg_addr = '0, src_clr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        data_ready, irq_rx, irq_err, tx_flush;

  int checks = 0, failures = 0;
  bit done = 0;
  bit fmode = 0;
  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];

  always #2.5 clk = ~clk;

  uart_rx_buffer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .brk_evt(brk_evt), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_clr(src_clr),
    .data_ready(data_ready), .irq_rx(irq_rx), .irq_err(irq_err), .tx_flush(tx_flush)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares popped bytes against the scoreboard
  always @(negedge clk) begin
    while (obs_q.size() > 0) begin
      logic [7:0] o, e;
      o = obs_q.pop_front();
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      check(o === e, "R4 fifo order", {24'd0, o}, {24'd0, e});
    end
  end

  task automatic model_in(input logic [7:0] b);
    if (fmode && exp_q.size() < DEPTH) exp_q.push_back(b);
  endtask

  task automatic push(input logic [7:0] b);
    push_valid = 1; push_data = b; model_in(b);
    @(negedge clk); push_valid = 0;
  endtask

  task automatic brk(input bit with_push);
    brk_evt = 1; push_valid = with_push; push_data = 8'h99; model_in(8'h00);
    @(negedge clk); brk_evt = 0; push_valid = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    if (a == 0) begin
      fmode = v[0];
      if (v[1]) exp_q.delete();
    end
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pop();
    logic [31:0] d;
    rd(2'd3, d);
    obs_q.push_back(d[7:0]);
  endtask

  task automatic clr();
    src_clr = 2'b11; @(negedge clk); src_clr = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check({data_ready, irq_rx, irq_err, tx_flush} == 4'b0, "R1 outputs", {28'd0, data_ready, irq_rx, irq_err, tx_flush}, 0);
    rd(2'd0, d); check(d == 0, "R1 control", d, 0);
    rd(2'd1, d); check(d == 0, "R1 status", d, 0);
    rd(2'd2, d); check(d == 0, "R1 error", d, 0);

    // R8 holding mode, R11 rx source
    push(8'h41); push(8'h42);
    check(data_ready && irq_rx, "R8 R11 ready and rx source", {30'd0, data_ready, irq_rx}, 3);
    rd(2'd3, d); check(d == 32'h42, "R8 holding overwrite", d, 32'h42);
    check(!data_ready, "R8 ready cleared on read", data_ready, 0);
    rd(2'd1, d); check(d == 0, "R8 fifo untouched", d, 0);
    clr();
    check(!irq_rx && !irq_err, "R11 clear", {30'd0, irq_rx, irq_err}, 0);
    // R11 set wins over clear
    src_clr = 2'b01; push(8'h43); src_clr = 0;
    check(irq_rx, "R11 set wins", irq_rx, 1);

    // R2 enable, R3 count, R4 and R5
    wr(2'd0, 32'h1);
    rd(2'd0, d); check(d == 1, "R2 enable readback", d, 1);
    push(8'h10); push(8'h20); push(8'h30);
    rd(2'd1, d); check(d == 3, "R3 count", d, 3);
    pop(); check(data_ready, "R5 ready kept", data_ready, 1);
    pop(); pop(); check(!data_ready, "R5 ready cleared on empty", data_ready, 0);

    // R7 empty read
    clr();
    rd(2'd3, d); check(d == 0, "R7 empty read data", d, 0);
    check(irq_err, "R7 error source", irq_err, 1);
    clr();

    // R3 full, R6 overflow
    for (int i = 0; i < DEPTH; i++) push(8'(i * 3 + 1));
    rd(2'd1, d); check(d == 32'h100, "R3 full count zero", d, 32'h100);
    push(8'hEE);
    check(irq_err && data_ready, "R6 overflow error", {30'd0, irq_err, data_ready}, 3);
    rd(2'd1, d); check(d == 32'h100, "R6 still full", d, 32'h100);
    for (int i = 0; i < DEPTH; i++) pop();
    rd(2'd1, d); check(d == 0, "R6 drained exactly depth", d, 0);
    clr();

    // R12 simultaneous push and pop
    push(8'h55); push(8'h66);
    push_valid = 1; push_data = 8'h77; model_in(8'h77);
    reg_rd = 1; reg_addr = 2'd3; #1 obs_q.push_back(reg_rdata[7:0]);
    @(negedge clk); push_valid = 0; reg_rd = 0;
    rd(2'd1, d); check(d == 2, "R12 count unchanged", d, 2);
    pop(); pop();

    // R9 R10 break
    clr();
    brk(0);
    check(irq_rx && data_ready, "R9 break as byte", {30'd0, irq_rx, data_ready}, 3);
    rd(2'd2, d); check(d == 8, "R10 break flag", d, 8);
    rd(2'd2, d); check(d == 0, "R10 clear on read", d, 0);
    pop();
    brk(1);
    rd(2'd1, d); check(d == 1, "R9 break over push", d, 1);
    pop();
    reg_rd = 1; reg_addr = 2'd2; brk_evt = 1; model_in(8'h00);
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; brk_evt = 0;
    check(d[3] == 1'b1, "R10 read value before clear", d, 8);
    rd(2'd2, d); check(d == 8, "R10 break survives read", d, 8);
    pop();

    // R2 flush bits
    push(8'hA1); push(8'hA2);
    wr(2'd0, 32'h3);
    rd(2'd1, d); check(d == 0, "R2 rx flush", d, 0);
    check(!data_ready, "R2 flush clears ready", data_ready, 0);
    rd(2'd0, d); check(d == 1, "R2 reset bits self clear", d, 1);
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h5;
    @(negedge clk); reg_wr = 0;
    check(tx_flush, "R2 tx flush pulse", tx_flush, 1);
    @(negedge clk);
    check(!tx_flush, "R2 tx flush one cycle", tx_flush, 0);

    // R8 mode switch keeps fifo
    push(8'h31);
    wr(2'd0, 32'h0);
    push(8'h32);
    rd(2'd3, d); check(d == 32'h32, "R8 holding after switch", d, 32'h32);
    wr(2'd0, 32'h1);
    pop();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule